// File: doc/BRIEF.md
# Single-Level Program Interrupt Controller

This block decides when a processor must abandon its normal instruction stream to service a peripheral. Fourteen device-ready flags, all level-sensitive, are merged into one request. That request is gated by an enable bit owned by the program. The enable and disable instructions (octal 700042 and 700002) are decoded upstream and arrive as single-cycle strobes.

At an instruction boundary where the controller is armed and any flag is high, the block issues a one-cycle break request. The sequencer then behaves as if a subroutine jump to location 0 had been executed: the packed status word is written to location 0 and execution resumes at the vector address, location 1. Because only one level exists, taking a break drops the enable. The same break also pulses strobes that clear extend mode and trap mode.

A fresh enable is held off for one more boundary, so that the jump returning from the service routine can complete first. The enable state drives a console indicator.

Top module: `pic_core`

## Requirements
- R1: After reset, break_req_o, enable_ind_o, extend_clr_o, trap_clr_o and save_word_o are all zero.
- R2: An enable strobe sets enable_ind_o on the next cycle. A disable strobe clears it on the next cycle. When both strobes are high together, disable wins.
- R3: When insn_done_i is high, the controller is enabled and not held off, and any flag is high, break_req_o is high for exactly the following cycle.
- R4: While disabled, no break occurs whatever the flags do. A flag still high when the controller is re-enabled causes a break.
- R5: An enable strobe holds off breaks until the first insn_done_i at or after the strobe has passed. The earliest break is taken at the next boundary after that one.
- R6: In the break cycle, save_word_o holds the state sampled at the boundary: save_word_o[17] = link (word bit 0, the most significant bit), [16] = extend, [15] = trap, [14:0] = program counter. It keeps that value until the next break.
- R7: In the break cycle, enable_ind_o is low and extend_clr_o and trap_clr_o are high; otherwise both clear strobes are low.
- R8: vector_addr_o always reads 1.
- R9: No break is taken in a cycle where insn_done_i is low, even with flags high and the controller enabled.
- R10: Each of the 14 flag positions alone is enough to cause a break.
- R11: An enable strobe coinciding with a boundary that takes a break is overridden: the enable ends up cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flags_i | input | 14 | Device-ready flags, level-sensitive |
| int_on_i | input | 1 | Decoded enable-instruction strobe |
| int_off_i | input | 1 | Decoded disable-instruction strobe |
| insn_done_i | input | 1 | Instruction boundary strobe |
| pc_i | input | 15 | Program counter to be saved |
| link_i | input | 1 | Link bit |
| extend_i | input | 1 | Extend mode status |
| trap_i | input | 1 | Trap mode status |
| break_req_o | output | 1 | One-cycle program break request |
| save_word_o | output | 18 | Status word for location 0 |
| vector_addr_o | output | 15 | Address where execution resumes |
| extend_clr_o | output | 1 | Clear extend mode strobe |
| trap_clr_o | output | 1 | Clear trap mode strobe |
| enable_ind_o | output | 1 | Console enable indicator |

## Verification
The bench targets the hold-off after an enable, in two cases: the strobe arrives before its boundary, and the strobe arrives on it. A design off by one boundary either breaks before the return jump completes or delays service by a whole instruction.

It also targets flags that rise while the controller is disabled. A design that latched edges instead of levels would drop those requests.

Further targets are a break that coincides with an enable strobe, and simultaneous enable and disable strobes. In both cases a wrong priority would leave the controller enabled and allow nested breaks.

Finally, every flag position is driven on its own, and the save word is checked with distinct field values. A swapped bit order or a missing flag in the merge would show up there.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_ON   = 2'd1,
    CMD_OFF  = 2'd2
  } en_cmd_e;

  typedef struct packed {
    logic link;
    logic extend;
    logic trap;
  } mode_bits_t;

  localparam int unsigned MODE_W = $bits(mode_bits_t);
endpackage

// File: rtl/pic_flag_merge.sv
module pic_flag_merge #(
  parameter int unsigned NUM_FLAGS = 14
) (
  input  logic [NUM_FLAGS-1:0] flags_i,
  output logic                 any_o
);
  logic [NUM_FLAGS:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_or
    assign chain[i+1] = chain[i] | flags_i[i];
  end
  assign any_o = chain[NUM_FLAGS];
endmodule

// File: rtl/pic_enable_ctl.sv
module pic_enable_ctl
  import pic_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  en_cmd_e cmd_i,
  input  logic    insn_done_i,
  input  logic    take_i,
  output logic    en_o,
  output logic    arm_o
);
  logic en_q, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0;
    end else if (take_i) begin
      en_q <= 1'b0;  // single level: break drops enable
    end else begin
      case (cmd_i)
        CMD_ON:  en_q <= 1'b1;
        CMD_OFF: en_q <= 1'b0;
        default: en_q <= en_q;
      endcase
    end
  end

  // hold-off until the boundary ending the enable instruction has passed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hold_q <= 1'b0;
    else if (insn_done_i)     hold_q <= 1'b0;
    else if (cmd_i == CMD_ON) hold_q <= 1'b1;
  end

  assign en_o  = en_q;
  assign arm_o = en_q & ~hold_q;

  assert_on_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_ON && !take_i) |=> en_o);
  assert_off_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_OFF) |=> !en_o);
  assert_hold_off_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_ON && !insn_done_i) |=> !arm_o);
  assert_take_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !en_o);
endmodule

// File: rtl/pic_break_gen.sv
module pic_break_gen
  import pic_pkg::*;
#(
  parameter int unsigned PC_W = 15,
  localparam int unsigned WORD_W = PC_W + MODE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              insn_done_i,
  input  logic              arm_i,
  input  logic              any_flag_i,
  input  logic [PC_W-1:0]   pc_i,
  input  mode_bits_t        mode_i,
  output logic              take_o,
  output logic              break_o,
  output logic [WORD_W-1:0] word_o
);
  logic              break_q;
  logic [WORD_W-1:0] word_q;

  assign take_o = insn_done_i & arm_i & any_flag_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      break_q <= 1'b0;
      word_q  <= '0;
    end else begin
      break_q <= take_o;
      if (take_o) word_q <= {mode_i, pc_i};
    end
  end

  assign break_o = break_q;
  assign word_o  = word_q;

  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_q |=> !break_q);
  assert_boundary_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_q |-> $past(insn_done_i));
  assert_word_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !break_q |=> (break_q || $stable(word_q)));
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
#(
  parameter int unsigned NUM_FLAGS = 14,
  parameter int unsigned PC_W      = 15,
  parameter int unsigned VEC_ADDR  = 1,
  localparam int unsigned WORD_W   = PC_W + MODE_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic                 int_on_i,
  input  logic                 int_off_i,
  input  logic                 insn_done_i,
  input  logic [PC_W-1:0]      pc_i,
  input  logic                 link_i,
  input  logic                 extend_i,
  input  logic                 trap_i,
  output logic                 break_req_o,
  output logic [WORD_W-1:0]    save_word_o,
  output logic [PC_W-1:0]      vector_addr_o,
  output logic                 extend_clr_o,
  output logic                 trap_clr_o,
  output logic                 enable_ind_o
);
  localparam logic [PC_W-1:0] VEC = PC_W'(VEC_ADDR);

  en_cmd_e    cmd;
  mode_bits_t mode;
  logic       any_flag, arm, take, en, brk;

  always_comb begin
    if (int_off_i)     cmd = CMD_OFF;  // disable wins
    else if (int_on_i) cmd = CMD_ON;
    else               cmd = CMD_NONE;
  end

  assign mode = '{link: link_i, extend: extend_i, trap: trap_i};

  pic_flag_merge #(.NUM_FLAGS(NUM_FLAGS)) i_merge (
    .flags_i (flags_i),
    .any_o   (any_flag)
  );

  pic_enable_ctl i_enable (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_i       (cmd),
    .insn_done_i (insn_done_i),
    .take_i      (take),
    .en_o        (en),
    .arm_o       (arm)
  );

  pic_break_gen #(.PC_W(PC_W)) i_break (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .insn_done_i (insn_done_i),
    .arm_i       (arm),
    .any_flag_i  (any_flag),
    .pc_i        (pc_i),
    .mode_i      (mode),
    .take_o      (take),
    .break_o     (brk),
    .word_o      (save_word_o)
  );

  assign break_req_o   = brk;
  assign extend_clr_o  = brk;
  assign trap_clr_o    = brk;
  assign enable_ind_o  = en;
  assign vector_addr_o = VEC;

  assert_break_clears_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_req_o |-> !enable_ind_o);
  assert_disabled_no_break_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_ind_o |=> !break_req_o);
  assert_word_fields_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    break_req_o |-> save_word_o == $past({link_i, extend_i, trap_i, pc_i}));
  assert_flag_break_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insn_done_i && arm && (flags_i != '0)) |=> break_req_o);
endmodule

// File: tb/test_pic_core.sv
module test_pic_core;
  localparam int CLK_PERIOD = 10;
  localparam int NF  = 14;
  localparam int PCW = 15;
  localparam int WW  = PCW + 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NF-1:0] flags = '0;
  logic on = 1'b0, off = 1'b0, done = 1'b0;
  logic [PCW-1:0] pc = '0;
  logic link = 1'b0, ext = 1'b0, trap = 1'b0;
  logic brk, ext_clr, trap_clr, en_ind;
  logic [WW-1:0] word;
  logic [PCW-1:0] vec;

  int checks = 0, errors = 0;
  bit cmp_on = 1'b0, finished = 1'b0;

  logic m_en, m_hold, m_brk;
  logic [WW-1:0] m_word;

  always #(CLK_PERIOD/2) clk = ~clk;

  pic_core i_pic_core (
    .clk_i(clk), .rst_ni(rst_n), .flags_i(flags), .int_on_i(on), .int_off_i(off),
    .insn_done_i(done), .pc_i(pc), .link_i(link), .extend_i(ext), .trap_i(trap),
    .break_req_o(brk), .save_word_o(word), .vector_addr_o(vec),
    .extend_clr_o(ext_clr), .trap_clr_o(trap_clr), .enable_ind_o(en_ind)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 0; m_hold <= 0; m_brk <= 0; m_word <= '0;
    end else begin
      automatic bit take = done && m_en && !m_hold && (flags != 0);
      m_brk <= take;
      if (take) m_word <= {link, ext, trap, pc};
      if (take || off) m_en <= 0;
      else if (on) m_en <= 1;
      if (done) m_hold <= 0;
      else if (on) m_hold <= 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on && rst_n) begin
    check("R3 model break_req", 32'(brk), 32'(m_brk));
    check("R2 model enable_ind", 32'(en_ind), 32'(m_en));
    check("R6 model save_word", 32'(word), 32'(m_word));
    check("R7 model extend_clr", 32'(ext_clr), 32'(m_brk));
    check("R7 model trap_clr", 32'(trap_clr), 32'(m_brk));
    check("R8 model vector", 32'(vec), 32'd1);
  end

  task automatic cyc(input logic [NF-1:0] f, input logic o, input logic x, input logic d);
    #1;
    flags = f; on = o; off = x; done = d;
    @(negedge clk);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset break", 32'(brk), 0);
    check("R1 reset enable", 32'(en_ind), 0);
    check("R1 reset word", 32'(word), 0);
    check("R1 reset clr", 32'({ext_clr, trap_clr}), 0);
    #1 rst_n = 1; cmp_on = 1;
    @(negedge clk);

    // R4: disabled, flags high
    for (int i = 0; i < 4; i++) cyc(14'h0040, 0, 0, 1);
    check("R4 disabled no break", 32'(brk), 0);

    // R5: enable strobe before its boundary
    cyc(0, 1, 0, 0);
    check("R2 enable set", 32'(en_ind), 1);
    pc = 15'h2AB5; link = 1; ext = 0; trap = 1;
    cyc(14'h0001, 0, 0, 1);
    check("R5 held at first boundary", 32'(brk), 0);
    pc = 15'h1234; link = 1; ext = 1; trap = 0;
    cyc(14'h0001, 0, 0, 1);
    check("R3 break taken", 32'(brk), 1);
    check("R6 word fields", 32'(word), 32'({1'b1, 1'b1, 1'b0, 15'h1234}));
    check("R7 enable dropped", 32'(en_ind), 0);
    check("R7 extend_clr", 32'(ext_clr), 1);
    check("R7 trap_clr", 32'(trap_clr), 1);
    check("R8 vector", 32'(vec), 1);
    pc = 15'h7FFF;
    cyc(14'h0001, 0, 0, 1);
    check("R3 single pulse", 32'(brk), 0);
    check("R6 word held", 32'(word), 32'({1'b1, 1'b1, 1'b0, 15'h1234}));

    // R4: flag still high, re-enable on its own boundary
    cyc(14'h0100, 1, 0, 1);
    check("R5 no break at enable boundary", 32'(brk), 0);
    pc = 15'h0005; link = 0; ext = 0; trap = 1;
    cyc(14'h0100, 0, 0, 1);
    check("R4 pending flag breaks", 32'(brk), 1);
    check("R6 word trap only", 32'(word), 32'({3'b001, 15'h0005}));

    // R9: enabled, flags high, no boundary
    cyc(0, 1, 0, 1);
    for (int i = 0; i < 5; i++) begin
      cyc(14'h2000, 0, 0, 0);
      check("R9 no break off boundary", 32'(brk), 0);
    end
    cyc(14'h2000, 0, 0, 1);
    check("R9 break at boundary", 32'(brk), 1);

    // R2: both strobes
    cyc(0, 1, 0, 1);
    check("R2 on", 32'(en_ind), 1);
    cyc(0, 1, 1, 0);
    check("R2 off wins", 32'(en_ind), 0);
    cyc(14'h0004, 0, 0, 1);
    check("R2 off no break", 32'(brk), 0);

    // R11: enable coinciding with a break
    cyc(0, 1, 0, 1);
    cyc(0, 0, 0, 0);
    cyc(14'h0010, 1, 0, 1);
    check("R11 break taken", 32'(brk), 1);
    check("R11 enable cleared", 32'(en_ind), 0);
    cyc(0, 0, 0, 0);
    check("R11 enable stays clear", 32'(en_ind), 0);

    // R10: each flag alone
    for (int i = 0; i < NF; i++) begin
      cyc(0, 1, 0, 1);
      cyc(NF'(1) << i, 0, 0, 1);
      check($sformatf("R10 flag %0d", i), 32'(brk), 1);
    end
    cyc(0, 0, 0, 0);

    // randomized traffic, checked by the reference every cycle
    for (int n = 0; n < 4000; n++) begin
      pc = PCW'($urandom); {link, ext, trap} = 3'($urandom);
      cyc(($urandom % 4 == 0) ? NF'($urandom) : '0,
          ($urandom % 6 == 0), ($urandom % 17 == 0), ($urandom % 3 == 0));
    end
    summary();
  end
endmodule